// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side answer logic for the SMBus alert response query in a temperature-sensing device. It keeps an alert flag that the limit-comparison logic raises, and it watches the two-wire bus through synchronized SCL and SDA samples. When a bus controller broadcasts the alert query byte `0x19` (address `0001100` with the read bit set), the block acknowledges only if its alert is active. It then returns its own 7-bit target address with a cause bit in the least significant position. The cause bit is 1 for an over-high-limit event and 0 for an under-low-limit event.

Several responders may answer the same query. The returned byte is arbitrated bit by bit on the wired-AND SDA line, so the lowest byte wins. A responder that releases SDA but reads it low has lost. It drops off the bus and keeps its alert asserted. The winner clears its alert on the controller's acknowledge clock that follows the byte, or on a STOP seen in that slot.

All logic runs on a system clock that oversamples the bus. SDA is open-drain: `sda_oe` high pulls the line low. The block never holds SCL low.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, `alert_o` is 0 and `sda_oe` is 0.
- R2: A one-cycle `alert_set` pulse sets `alert_o`. It then stays 1 until the block wins an alert response.
- R3: When the received byte after a START is `0x19` (MSB first), the block pulls SDA low during the ninth clock if `alert_o` is 1. If `alert_o` is 0, it leaves SDA released.
- R4: Any other received byte gets no acknowledge and leaves `alert_o` unchanged.
- R5: After acknowledging, the block sends one byte MSB first: `own_addr[6:0]` followed by the cause bit, with 1 meaning above the high limit. A 1 bit leaves SDA released and a 0 bit pulls SDA low.
- R6: The address and cause bit are captured on the SCL falling edge that ends the acknowledge clock. Later changes on `own_addr` or `cause_hi` do not alter the byte being sent.
- R7: If the block releases SDA for a bit but samples SDA low on that bit's SCL rising edge, it has lost. It releases SDA for the rest of the byte, and `alert_o` stays 1.
- R8: If the block sends all eight bits without losing, `alert_o` falls after the SCL rising edge of the controller's acknowledge or not-acknowledge clock. A STOP seen in that slot has the same effect.
- R9: A START or STOP at any point releases SDA and resets the bit sequence. A STOP before the byte is complete leaves `alert_o` set.
- R10: `sda_oe` only goes from 0 to 1 while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | This target's 7-bit bus address |
| alert_set | input | 1 | One-cycle pulse raising the alert |
| cause_hi | input | 1 | Alert cause: 1 above high limit, 0 below low limit |
| alert_o | output | 1 | Alert active flag |

## Verification
A wrong bit count or a wrong state shows up on `sda_oe` within one bus bit. The acknowledge then lands in the wrong clock, or a bit of the returned byte is missing or shifted. The bench compares `sda_oe` with a model on every returned bit. An arbitration fault appears within the same bit as a pulled-low SDA after a loss. It also appears one byte later as a wrong `alert_o` after the controller's acknowledge clock. A start or stop detector that misses an event leaves the next query unacknowledged, which the bench sees at its ninth clock.

// File: rtl/smb_alert_pkg.sv
// Shared constants and types for the alert response responder.
package smb_alert_pkg;

    // Alert query byte: 7-bit address 0001100 followed by the read bit.
    localparam logic [7:0] ARA_QUERY = 8'h19;

    // Bit-level sequence of the responder.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SETUP,
        ST_ACK,
        ST_TX,
        ST_CTRL_ACK
    } ara_state_t;

endpackage

// File: rtl/smb_sync.sv
// Multi-flop synchronizer for one asynchronous bus line.
// Assumes the line idles at RESET_VAL (bus released is high).
module smb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
// Detects SCL edges and START/STOP conditions from synchronized lines.
// Assumes both inputs are already synchronized to clk.
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Hold the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and condition decode from previous and current samples.
    always_comb begin
        scl_rise  = !scl_q && scl_s;
        scl_fall  = scl_q && !scl_s;
        start_det = scl_q && scl_s && sda_q && !sda_s;
        stop_det  = scl_q && scl_s && !sda_q && sda_s;
    end
endmodule

// File: rtl/smb_ara_fsm.sv
// Bit sequencer for the alert response: receives the query byte,
// acknowledges when alert is active, sends {address, cause} with
// arbitration, and flags a win at the controller acknowledge clock.
// Assumes event pulses are single-cycle and derived from synced lines.
module smb_ara_fsm
    import smb_alert_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic              alert_active,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              cause_hi,
    output logic              sda_oe,
    output logic              win_clear,
    output ara_state_t        state_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] QUERY    = BYTE_W'(ARA_QUERY);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  ALL_BITS = CNT_W'(BYTE_W);

    ara_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_next;

    // Query byte including the bit currently on SDA.
    assign rx_next = {rx_sr[BYTE_W-2:0], sda_s};

    // Bit sequence, SDA drive and win pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            sda_oe    <= 1'b0;
            win_clear <= 1'b0;
        end else begin
            win_clear <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                if (state == ST_CTRL_ACK) win_clear <= 1'b1;
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sr   <= rx_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                state <= (rx_next == QUERY && alert_active)
                                         ? ST_ACK_SETUP : ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_SETUP: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            tx_sr   <= {own_addr, cause_hi};
                            sda_oe  <= !own_addr[ADDR_W-1];
                            bit_cnt <= '0;
                            state   <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            if (!sda_oe && !sda_s) begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end else if (scl_fall) begin
                            if (bit_cnt == ALL_BITS) begin
                                sda_oe <= 1'b0;
                                state  <= ST_CTRL_ACK;
                            end else begin
                                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= !tx_sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_CTRL_ACK: begin
                        if (scl_rise) begin
                            win_clear <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign state_o = state;
endmodule

// File: rtl/smb_alert_responder.sv
// Top of the alert response responder: synchronizes the bus lines,
// decodes bus events, runs the bit sequencer and holds the alert flag.
// Assumes open-drain SDA (sda_oe=1 pulls low) and that SCL is never
// stretched by this block.
module smb_alert_responder
    import smb_alert_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              alert_set,
    input  logic              cause_hi,
    output logic              alert_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic win_clear;
    ara_state_t fsm_state;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        smb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (line_raw[g]),
            .q     (line_s[g])
        );
    end

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    smb_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_ara_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_s        (sda_s),
        .alert_active (alert_o),
        .own_addr     (own_addr),
        .cause_hi     (cause_hi),
        .sda_oe       (sda_oe),
        .win_clear    (win_clear),
        .state_o      (fsm_state)
    );

    // Alert flag: raised by a set pulse, dropped after a won response.
    always_ff @(posedge clk) begin
        if (!rst_n)         alert_o <= 1'b0;
        else if (alert_set) alert_o <= 1'b1;
        else if (win_clear) alert_o <= 1'b0;
    end
endmodule

// File: rtl/smb_alert_chk.sv
// Property checker for the alert response responder, bound to the top.
module smb_alert_chk
    import smb_alert_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_s,
    input logic       scl_rise,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       alert_o,
    input logic       alert_set,
    input ara_state_t state
);
    // R2
    alert_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_set |=> alert_o);

    // R3
    ack_needs_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> alert_o);

    // R7
    lose_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && scl_rise && !sda_oe && !sda_s && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe));

    // R8
    clear_after_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_o) |-> ($past(state, 2) == ST_CTRL_ACK));

    // R9
    start_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && !sda_oe));

    // R9
    stop_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

    // R10
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind smb_alert_responder smb_alert_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .alert_o   (alert_o),
    .alert_set (alert_set),
    .state     (fsm_state)
);

// File: tb/smb_alert_responder_tb.sv
// Bench: bus controller and one competing responder modelled in tasks;
// directed corner cases plus seeded random transactions.
module smb_alert_responder_tb;
    localparam int H = 8;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       m_oe = 1'b0;
    logic       oth_oe = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [6:0] own_addr = 7'h00;
    logic       alert_set = 1'b0;
    logic       cause_hi = 1'b0;
    logic       alert_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  alert_model = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = !(sda_oe || m_oe || oth_oe);

    smb_alert_responder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_drv),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .own_addr  (own_addr),
        .alert_set (alert_set),
        .cause_hi  (cause_hi),
        .alert_o   (alert_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R10: SDA pull-down only starts while SCL is low.
    always @(posedge sda_oe) begin
        if (rst_n && !done) chk("R10 drive while scl low", scl_drv, 1'b0);
    end

    // Expected wired byte from the responders still on the bus.
    function automatic logic [7:0] exp_wire(input logic [7:0] db, input logic [7:0] cb,
                                           input bit d_on, input bit c_on);
        if (d_on && c_on) return (db < cb) ? db : cb;
        if (d_on) return db;
        if (c_on) return cb;
        return 8'hFF;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        m_oe = 1'b0; oth_oe = 1'b0;
        wait_n(Q); scl_drv = 1'b1;
        wait_n(H); m_oe = 1'b1;
        wait_n(H); scl_drv = 1'b0;
    endtask

    task automatic stop_cond();
        wait_n(Q); m_oe = 1'b1; oth_oe = 1'b0;
        wait_n(Q); scl_drv = 1'b1;
        wait_n(H); m_oe = 1'b0;
        wait_n(H);
    endtask

    task automatic write_bit(input logic b);
        wait_n(Q); m_oe = !b;
        wait_n(Q); scl_drv = 1'b1;
        wait_n(H); scl_drv = 1'b0;
    endtask

    task automatic read_bit(input logic comp_drive, output logic w, output logic d);
        wait_n(Q); m_oe = 1'b0; oth_oe = comp_drive;
        wait_n(Q); scl_drv = 1'b1;
        wait_n(Q); w = sda_line; d = sda_oe;
        wait_n(Q); scl_drv = 1'b0;
    endtask

    task automatic pulse_alert();
        @(negedge clk); alert_set = 1'b1;
        @(negedge clk); alert_set = 1'b0;
        alert_model = 1'b1;
        chk("R2 alert raised", alert_o, 1'b1);
    endtask

    // One query transaction with an optional competitor and early stop.
    task automatic run_txn(input logic [7:0] qb, input bit comp, input logic [7:0] cb,
                           input bit stop_early);
        logic w, d;
        logic [7:0] db, wire_byte;
        bit exp_ack, dut_on, comp_on, comp_start, dut_win;
        exp_ack = (qb == 8'h19) && alert_model;
        comp_on = comp && (qb == 8'h19);
        comp_start = comp_on;
        start_cond();
        for (int i = 7; i >= 0; i--) write_bit(qb[i]);
        db = {own_addr, cause_hi};
        read_bit(comp_on, w, d);
        chk(qb == 8'h19 ? "R3 ack gated by alert" : "R4 no ack other byte", d, exp_ack);
        if (!exp_ack && !comp_on) begin
            stop_cond();
            chk("R4 alert unchanged", alert_o, alert_model);
            return;
        end
        if (stop_early) begin
            stop_cond();
            chk("R9 released after stop", sda_oe, 1'b0);
            chk("R9 alert kept", alert_o, alert_model);
            return;
        end
        dut_on = exp_ack;
        wire_byte = '0;
        for (int i = 7; i >= 0; i--) begin
            read_bit(comp_on && !cb[i], w, d);
            chk("R5/R7 bit drive", d, dut_on && !db[i]);
            wire_byte[i] = w;
            if (dut_on && db[i] && !w) dut_on = 1'b0;
            if (comp_on && cb[i] && !w) comp_on = 1'b0;
            if (i == 7) begin
                cause_hi = !cause_hi;
                own_addr = ~own_addr;
            end
        end
        chk("R5/R6/R7 returned byte", wire_byte, exp_wire(db, cb, exp_ack, comp_start));
        dut_win = exp_ack && (!comp_start || db <= cb);
        write_bit(1'b1);
        if (dut_win) alert_model = 1'b0;
        chk("R7/R8 alert after ack clock", alert_o, alert_model);
        stop_cond();
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20471);
        wait_n(4);
        chk("R1 reset alert", alert_o, 1'b0);
        chk("R1 reset sda", sda_oe, 1'b0);
        rst_n = 1'b1;
        wait_n(4);

        own_addr = 7'h48; cause_hi = 1'b1;
        run_txn(8'h19, 1'b0, 8'h00, 1'b0);          // R3 no alert, no ack
        pulse_alert();
        run_txn(8'h18, 1'b0, 8'h00, 1'b0);          // R4 wrong byte
        run_txn(8'h99, 1'b0, 8'h00, 1'b0);          // R4 wrong byte
        run_txn(8'h19, 1'b1, 8'h20, 1'b0);          // R7 lower competitor wins
        run_txn(8'h19, 1'b1, 8'hF1, 1'b0);          // R8 win over higher competitor
        own_addr = 7'h55; cause_hi = 1'b0;
        pulse_alert();
        run_txn(8'h19, 1'b0, 8'h00, 1'b1);          // R9 stop before byte done
        own_addr = 7'h55;
        // R9 repeated start mid-query restarts the bit count
        start_cond();
        for (int i = 0; i < 3; i++) write_bit(1'b0);
        run_txn(8'h19, 1'b0, 8'h00, 1'b0);          // R5/R6/R8 plain win

        for (int k = 0; k < 30; k++) begin
            logic [7:0] qb, cb;
            if ($urandom % 2 == 0) pulse_alert();
            own_addr = 7'($urandom);
            cause_hi = 1'($urandom);
            qb = ($urandom % 4 == 0) ? 8'($urandom) : 8'h19;
            cb = 8'($urandom);
            run_txn(qb, 1'($urandom), cb, 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule